// File: doc/BRIEF.md
# Virtual JTAG Hub with Descriptor Enumeration

This hub sits behind a physical JTAG TAP and lets several user debug nodes share two user instructions. It receives the decoded physical instruction, the capture, shift and update strobes for the data register, a test-logic-reset level, TCK and TDI, and it drives TDO. While the first user instruction (IR code 0x0E) is active, every data scan goes into a virtual instruction register. That register holds a node address in its upper n bits and a node-local instruction in its lower m bits. Address 0 is the hub itself.

While the second user instruction (IR code 0x0C) is active, the hub does one of two things. With address 0 and instruction 0 (the hub-information command) it returns a 32-bit configuration word, followed by one 32-bit descriptor per node. These come out as 4-bit scans, and each scan must be closed by an update before the next nibble is offered. With a node address it routes TDI and TDO to that node alone, and gives that node a select line and the latched instruction.

Host software first loads all zeros into the virtual instruction register, using any number of bits. It then reads the hub word to learn m and the node count. It reads the node descriptors in order, and the k-th descriptor read (counting from 0) belongs to address k+1. Finally it loads that address together with the node's command, for example 0x8 for a debug node.

Top module: `vjtag_hub`

## Requirements
- R1: When tlr is high, the latched address and instruction, the descriptor nibble pointer and both shift registers are cleared on the next TCK edge. No node is selected while the latched address is zero.
- R2: With irValue = 0x0E, each shiftDr cycle shifts TDI into the top of the n+m bit virtual register, and bit 0 appears on TDO. The bits are therefore loaded LSB first. updateDr latches bits [n+m-1:m] as the address and bits [m-1:0] as the instruction. n = ceil(log2(NODE_COUNT+1)).
- R3: A virtual-register load of all zeros that is longer than n+m bits (64 bits, for example) leaves address 0 and instruction 0, which selects hub information.
- R4: Under hub information with irValue = 0x0C, captureDr loads the current 4-bit nibble and four shiftDr cycles return it LSB first on TDO. The least significant nibble of each 32-bit word is returned first.
- R5: The hub word is laid out as [31:27] hub version, [26:19] node count, [18:8] 0x06E and [7:0] m.
- R6: The nibble pointer moves forward only on updateDr. A capture and shift with no update returns the same nibble again.
- R7: The hub word is followed by the node descriptors in address order. Once the last one has been read, the hub returns zeros.
- R8: Any virtual-register update returns the nibble pointer to nibble 0 of the hub word.
- R9: With irValue = 0x0C and a latched address k+1 (1 ≤ k+1 ≤ NODE_COUNT), only nodeSel[k] is high, nodeTdi[k] follows TDI, TDO follows nodeTdo[k], and nodeIr holds the latched instruction.
- R10: In all other cases nodeSel is all zero and every nodeTdi bit is zero. This covers a physical instruction other than 0x0C, and address 0. With address 0 and a non-zero instruction, TDO is also 0.
- R11: A captureDr with irValue = 0x0E loads the latched address and instruction into the virtual register, so the current value can be shifted back out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tlr | input | 1 | High while the TAP is in test-logic-reset |
| irValue | input | IR_W | Decoded physical instruction |
| captureDr | input | 1 | Capture-DR strobe |
| shiftDr | input | 1 | Shift-DR strobe |
| updateDr | input | 1 | Update-DR strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| nodeTdo | input | NODE_COUNT | Serial data returned by each node |
| nodeTdi | output | NODE_COUNT | Serial data gated to each node |
| nodeSel | output | NODE_COUNT | One-hot node select |
| nodeIr | output | M_W | Latched node instruction |
| virAddrOut | output | N_W | Latched node address |

## Verification
The bench builds the hub with three nodes and a 4-bit node instruction, so the address field is two bits wide and address 3 is the last one that can be encoded. Every address value therefore maps to a real node, and a single overlong 8-bit load can reach the highest node. With four descriptor words, a full enumeration takes 32 nibble scans. The bench reads one further word past that point, which exercises the pointer saturating and the hub returning zeros.

// File: rtl/vjtag_hub_pkg.sv
package vjtag_hub_pkg;

  localparam logic [10:0] HUB_MFG_ID = 11'h06E;

  typedef enum logic [1:0] {
    PATH_NONE,
    PATH_VIR,
    PATH_INFO,
    PATH_NODE
  } pathE;

  typedef struct packed {
    logic clear;
    logic virCapture;
    logic virShift;
    logic virUpdate;
    logic infoCapture;
    logic infoShift;
    logic infoAdvance;
  } ctrlS;

endpackage

// File: rtl/vjtag_hub_ctrl.sv
module vjtag_hub_ctrl
  import vjtag_hub_pkg::*;
#(
  parameter int IR_W = 10,
  parameter logic [IR_W-1:0] SEL_VIR_CODE = 'h0E,
  parameter logic [IR_W-1:0] SEL_DATA_CODE = 'h0C,
  parameter int NODE_COUNT = 3,
  parameter int N_W = 2,
  parameter int M_W = 4
) (
  input  logic [IR_W-1:0] irValue,
  input  logic            tlr,
  input  logic            captureDr,
  input  logic            shiftDr,
  input  logic            updateDr,
  input  logic [N_W-1:0]  virAddr,
  input  logic [M_W-1:0]  virInstr,
  output ctrlS            ctrl,
  output pathE            path
);

  always_comb begin
    path = PATH_NONE;
    if (irValue == SEL_VIR_CODE) begin
      path = PATH_VIR;
    end else if (irValue == SEL_DATA_CODE) begin
      if (virAddr == '0) begin
        if (virInstr == '0) path = PATH_INFO;
      end else if (int'(virAddr) <= NODE_COUNT) begin
        path = PATH_NODE;
      end
    end
  end

  always_comb begin
    ctrl.clear       = tlr;
    ctrl.virCapture  = (path == PATH_VIR)  && captureDr;
    ctrl.virShift    = (path == PATH_VIR)  && shiftDr;
    ctrl.virUpdate   = (path == PATH_VIR)  && updateDr;
    ctrl.infoCapture = (path == PATH_INFO) && captureDr;
    ctrl.infoShift   = (path == PATH_INFO) && shiftDr;
    ctrl.infoAdvance = (path == PATH_INFO) && updateDr;
  end

endmodule

// File: rtl/vjtag_hub_dp.sv
module vjtag_hub_dp
  import vjtag_hub_pkg::*;
#(
  parameter int NODE_COUNT = 3,
  parameter int M_W = 4,
  parameter int N_W = 2,
  parameter logic [4:0] HUB_VER = 5'd1,
  parameter logic [NODE_COUNT*32-1:0] NODE_INFO = '0
) (
  input  logic           tck,
  input  ctrlS           ctrl,
  input  logic           tdi,
  output logic [N_W-1:0] virAddr,
  output logic [M_W-1:0] virInstr,
  output logic           virBit,
  output logic           infoBit
);

  localparam int VIR_W     = N_W + M_W;
  localparam int WORDS     = NODE_COUNT + 1;
  localparam int NIB_TOTAL = 8 * WORDS;
  localparam int PTR_W     = $clog2(NIB_TOTAL + 1);

  localparam logic [31:0] HUB_WORD =
    {HUB_VER, 8'(NODE_COUNT), HUB_MFG_ID, 8'(M_W)};

  logic [VIR_W-1:0] virSr;
  logic [PTR_W-1:0] nibPtr;
  logic [3:0]       nibSr;
  logic [31:0]      descWord [WORDS];
  logic [31:0]      curWord;
  logic [3:0]       curNib;

  assign descWord[0] = HUB_WORD;
  for (genvar k = 0; k < NODE_COUNT; k++) begin : g_desc
    assign descWord[k+1] = NODE_INFO[k*32 +: 32];
  end

  always_comb begin
    curWord = '0;
    for (int w = 0; w < WORDS; w++) begin
      if (int'(nibPtr[PTR_W-1:3]) == w) curWord = descWord[w];
    end
    if (int'(nibPtr) >= NIB_TOTAL) curWord = '0;
    curNib = '0;
    for (int q = 0; q < 8; q++) begin
      if (int'(nibPtr[2:0]) == q) curNib = curWord[q*4 +: 4];
    end
  end

  always_ff @(posedge tck) begin
    if (ctrl.clear) begin
      virSr    <= '0;
      virAddr  <= '0;
      virInstr <= '0;
      nibPtr   <= '0;
      nibSr    <= '0;
    end else begin
      if (ctrl.virCapture)    virSr <= {virAddr, virInstr};
      else if (ctrl.virShift) virSr <= {tdi, virSr[VIR_W-1:1]};

      if (ctrl.virUpdate) begin
        {virAddr, virInstr} <= virSr;
        nibPtr <= '0;
      end else if (ctrl.infoAdvance && int'(nibPtr) < NIB_TOTAL) begin
        nibPtr <= nibPtr + 1'b1;
      end

      if (ctrl.infoCapture)    nibSr <= curNib;
      else if (ctrl.infoShift) nibSr <= {tdi, nibSr[3:1]};
    end
  end

  assign virBit  = virSr[0];
  assign infoBit = nibSr[0];

endmodule

// File: rtl/vjtag_hub.sv
module vjtag_hub
  import vjtag_hub_pkg::*;
#(
  parameter int IR_W = 10,
  parameter logic [IR_W-1:0] SEL_VIR_CODE = 'h0E,
  parameter logic [IR_W-1:0] SEL_DATA_CODE = 'h0C,
  parameter int NODE_COUNT = 3,
  parameter int M_W = 4,
  parameter logic [4:0] HUB_VER = 5'd1,
  parameter logic [NODE_COUNT*32-1:0] NODE_INFO =
    {32'h12A92300, 32'h08406E01, 32'h08406E00},
  localparam int N_W = $clog2(NODE_COUNT + 1)
) (
  input  logic                  tck,
  input  logic                  tlr,
  input  logic [IR_W-1:0]       irValue,
  input  logic                  captureDr,
  input  logic                  shiftDr,
  input  logic                  updateDr,
  input  logic                  tdi,
  output logic                  tdo,
  input  logic [NODE_COUNT-1:0] nodeTdo,
  output logic [NODE_COUNT-1:0] nodeTdi,
  output logic [NODE_COUNT-1:0] nodeSel,
  output logic [M_W-1:0]        nodeIr,
  output logic [N_W-1:0]        virAddrOut
);

  ctrlS           ctrl;
  pathE           path;
  logic [N_W-1:0] virAddr;
  logic [M_W-1:0] virInstr;
  logic           virBit;
  logic           infoBit;
  logic           nodeBit;

  vjtag_hub_ctrl #(
    .IR_W(IR_W), .SEL_VIR_CODE(SEL_VIR_CODE), .SEL_DATA_CODE(SEL_DATA_CODE),
    .NODE_COUNT(NODE_COUNT), .N_W(N_W), .M_W(M_W)
  ) i_ctrl (
    .irValue(irValue), .tlr(tlr), .captureDr(captureDr), .shiftDr(shiftDr),
    .updateDr(updateDr), .virAddr(virAddr), .virInstr(virInstr),
    .ctrl(ctrl), .path(path)
  );

  vjtag_hub_dp #(
    .NODE_COUNT(NODE_COUNT), .M_W(M_W), .N_W(N_W),
    .HUB_VER(HUB_VER), .NODE_INFO(NODE_INFO)
  ) i_dp (
    .tck(tck), .ctrl(ctrl), .tdi(tdi), .virAddr(virAddr),
    .virInstr(virInstr), .virBit(virBit), .infoBit(infoBit)
  );

  for (genvar k = 0; k < NODE_COUNT; k++) begin : g_node
    assign nodeSel[k] = (path == PATH_NODE) && (int'(virAddr) == k + 1);
    assign nodeTdi[k] = nodeSel[k] & tdi;
  end

  always_comb begin
    nodeBit = 1'b0;
    for (int k = 0; k < NODE_COUNT; k++) begin
      if (nodeSel[k]) nodeBit = nodeTdo[k];
    end
  end

  always_comb begin
    unique case (path)
      PATH_VIR:  tdo = virBit;
      PATH_INFO: tdo = infoBit;
      PATH_NODE: tdo = nodeBit;
      default:   tdo = 1'b0;
    endcase
  end

  assign nodeIr     = virInstr;
  assign virAddrOut = virAddr;

endmodule

// File: rtl/vjtag_hub_chk.sv
module vjtag_hub_chk #(
  parameter int IR_W = 10,
  parameter logic [IR_W-1:0] SEL_VIR_CODE = 'h0E,
  parameter logic [IR_W-1:0] SEL_DATA_CODE = 'h0C,
  parameter int NODE_COUNT = 3,
  parameter int M_W = 4,
  parameter int N_W = 2
) (
  input logic                  tck,
  input logic                  tlr,
  input logic [IR_W-1:0]       irValue,
  input logic                  updateDr,
  input logic                  tdo,
  input logic [NODE_COUNT-1:0] nodeTdo,
  input logic [NODE_COUNT-1:0] nodeTdi,
  input logic [NODE_COUNT-1:0] nodeSel,
  input logic [M_W-1:0]        nodeIr,
  input logic [N_W-1:0]        virAddrOut
);

  a_r1_clear_on_reset: assert property (@(posedge tck) disable iff (tlr)
    $past(tlr) |-> (virAddrOut == '0 && nodeIr == '0 && nodeSel == '0));

  a_r2_hold_without_update: assert property (@(posedge tck) disable iff (tlr)
    !(updateDr && irValue == SEL_VIR_CODE) |=> ($stable(virAddrOut) && $stable(nodeIr)));

  a_r9_tdi_gated: assert property (@(posedge tck) disable iff (tlr)
    (nodeTdi & ~nodeSel) == '0);

  a_r9_tdo_from_node: assert property (@(posedge tck) disable iff (tlr)
    (nodeSel != '0) |-> (tdo == |(nodeTdo & nodeSel)));

  a_r10_one_select: assert property (@(posedge tck) disable iff (tlr)
    $onehot0(nodeSel));

  a_r10_select_needs_data_ir: assert property (@(posedge tck) disable iff (tlr)
    (irValue != SEL_DATA_CODE || virAddrOut == '0) |-> (nodeSel == '0));

endmodule

bind vjtag_hub vjtag_hub_chk #(
  .IR_W(IR_W), .SEL_VIR_CODE(SEL_VIR_CODE), .SEL_DATA_CODE(SEL_DATA_CODE),
  .NODE_COUNT(NODE_COUNT), .M_W(M_W), .N_W(N_W)
) i_chk (
  .tck(tck), .tlr(tlr), .irValue(irValue), .updateDr(updateDr), .tdo(tdo),
  .nodeTdo(nodeTdo), .nodeTdi(nodeTdi), .nodeSel(nodeSel), .nodeIr(nodeIr),
  .virAddrOut(virAddrOut)
);

// File: tb/test_vjtag_hub.sv
module test_vjtag_hub;

  localparam int IR_W = 10;
  localparam int NODES = 3;
  localparam int MW = 4;
  localparam int NW = 2;
  localparam logic [IR_W-1:0] IR_VIR  = 10'h00E;
  localparam logic [IR_W-1:0] IR_DATA = 10'h00C;
  localparam logic [IR_W-1:0] IR_OTHER = 10'h003;

  function automatic logic [31:0] mkWord(input int ver, input int id, input int mfg, input int inst);
    return {5'(ver), 8'(id), 11'(mfg), 8'(inst)};
  endfunction

  localparam logic [31:0] NODE0 = mkWord(1, 8'h08, 11'h06E, 0);
  localparam logic [31:0] NODE1 = mkWord(1, 8'h08, 11'h06E, 1);
  localparam logic [31:0] NODE2 = mkWord(2, 8'h55, 11'h123, 0);
  localparam logic [31:0] HUBW  = mkWord(1, NODES, 11'h06E, MW);

  localparam logic [31:0] EXP_WORDS [5] = '{HUBW, NODE0, NODE1, NODE2, 32'h0};

  logic tck = 1'b0;
  logic tlr = 1'b1;
  logic [IR_W-1:0] irValue = '0;
  logic captureDr = 1'b0, shiftDr = 1'b0, updateDr = 1'b0, tdi = 1'b0;
  logic tdo;
  logic [NODES-1:0] nodeTdo = '0;
  logic [NODES-1:0] nodeTdi, nodeSel;
  logic [MW-1:0] nodeIr;
  logic [NW-1:0] virAddrOut;

  int nChecks = 0;
  int nFail = 0;

  always #4 tck = ~tck;

  vjtag_hub #(
    .IR_W(IR_W), .NODE_COUNT(NODES), .M_W(MW),
    .NODE_INFO({NODE2, NODE1, NODE0})
  ) i_vjtag_hub (
    .tck(tck), .tlr(tlr), .irValue(irValue), .captureDr(captureDr),
    .shiftDr(shiftDr), .updateDr(updateDr), .tdi(tdi), .tdo(tdo),
    .nodeTdo(nodeTdo), .nodeTdi(nodeTdi), .nodeSel(nodeSel),
    .nodeIr(nodeIr), .virAddrOut(virAddrOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge tck);
    @(negedge tck);
  endtask

  task automatic virLoad(input logic [63:0] val, input int len);
    irValue = IR_VIR;
    captureDr = 1'b1; step(); captureDr = 1'b0;
    shiftDr = 1'b1;
    for (int i = 0; i < len; i++) begin
      tdi = val[i];
      step();
    end
    shiftDr = 1'b0; tdi = 1'b0;
    updateDr = 1'b1; step(); updateDr = 1'b0;
  endtask

  task automatic readNib(output logic [3:0] nib, input bit doUpdate);
    irValue = IR_DATA;
    captureDr = 1'b1; step(); captureDr = 1'b0;
    shiftDr = 1'b1; tdi = 1'b0;
    for (int i = 0; i < 4; i++) begin
      #1 nib[i] = tdo;
      step();
    end
    shiftDr = 1'b0;
    if (doUpdate) begin
      updateDr = 1'b1; step(); updateDr = 1'b0;
    end
  endtask

  task automatic readWord(output logic [31:0] w);
    logic [3:0] nib;
    for (int q = 0; q < 8; q++) begin
      readNib(nib, 1'b1);
      w[q*4 +: 4] = nib;
    end
  endtask

  initial begin
    repeat (100000) @(posedge tck);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [31:0] w;
    logic [3:0] nib;
    logic [5:0] back;
    @(negedge tck);
    step(); step(); step();
    // R1: state after test-logic-reset
    #1;
    check("R1 addr", 32'(virAddrOut), 0);
    check("R1 instr", 32'(nodeIr), 0);
    check("R1 sel", 32'(nodeSel), 0);
    tlr = 1'b0;
    step();

    // R3: overlong zero load selects hub information
    virLoad(64'h0, 64);
    check("R3 addr", 32'(virAddrOut), 0);
    check("R3 instr", 32'(nodeIr), 0);

    // R4 R5 R7: enumeration walk over the expected descriptor table
    for (int k = 0; k < 5; k++) begin
      readWord(w);
      check(k == 0 ? "R5 hub word" : (k == 4 ? "R7 past end" : "R7 node word"), w, EXP_WORDS[k]);
    end

    // R8 and R6: restart on update, no advance without update
    virLoad(64'h0, 64);
    readNib(nib, 1'b1); check("R8 nib0", 32'(nib), 32'(HUBW[3:0]));
    readNib(nib, 1'b1); check("R4 nib1", 32'(nib), 32'(HUBW[7:4]));
    readNib(nib, 1'b0); check("R6 nib2 first", 32'(nib), 32'(HUBW[11:8]));
    readNib(nib, 1'b0); check("R6 nib2 repeat", 32'(nib), 32'(HUBW[11:8]));
    readNib(nib, 1'b1); check("R6 nib2 closed", 32'(nib), 32'(HUBW[11:8]));
    readNib(nib, 1'b1); check("R6 nib3", 32'(nib), 32'(HUBW[15:12]));

    // R1: test-logic-reset mid-enumeration
    tlr = 1'b1; step(); tlr = 1'b0;
    readNib(nib, 1'b1); check("R1 ptr restart", 32'(nib), 32'(HUBW[3:0]));

    // R2 R9: select node at address 2 with debug command 0x8
    virLoad(64'h28, 6);
    check("R2 addr", 32'(virAddrOut), 2);
    check("R2 instr", 32'(nodeIr), 8);
    irValue = IR_DATA; nodeTdo = 3'b010; tdi = 1'b1; shiftDr = 1'b1;
    #1;
    check("R9 sel", 32'(nodeSel), 32'h2);
    check("R9 tdi", 32'(nodeTdi), 32'h2);
    check("R9 tdo high", 32'(tdo), 1);
    nodeTdo = 3'b101;
    #1;
    check("R9 tdo low", 32'(tdo), 0);
    step();
    shiftDr = 1'b0; tdi = 1'b0;

    // R10: no select under another instruction
    irValue = IR_VIR;
    #1 check("R10 sel vir", 32'(nodeSel), 0);
    irValue = IR_OTHER; tdi = 1'b1;
    #1;
    check("R10 sel other", 32'(nodeSel), 0);
    check("R10 tdi other", 32'(nodeTdi), 0);
    tdi = 1'b0;
    step();

    // R11: capture under the virtual instruction path reads back latched value
    irValue = IR_VIR;
    captureDr = 1'b1; step(); captureDr = 1'b0;
    shiftDr = 1'b1;
    for (int i = 0; i < 6; i++) begin
      #1 back[i] = tdo;
      step();
    end
    shiftDr = 1'b0;
    check("R11 readback", 32'(back), 32'h28);

    // R2: overlong non-zero load keeps the last n+m bits
    virLoad(64'hE3, 8);
    check("R2 long addr", 32'(virAddrOut), 3);
    check("R2 long instr", 32'(nodeIr), 8);
    irValue = IR_DATA;
    #1 check("R9 sel node3", 32'(nodeSel), 32'h4);
    step();

    // R10: hub address with non-zero instruction
    virLoad(64'h05, 6);
    irValue = IR_DATA; nodeTdo = 3'b111;
    captureDr = 1'b1; step(); captureDr = 1'b0;
    shiftDr = 1'b1;
    #1;
    check("R10 hub other sel", 32'(nodeSel), 0);
    check("R10 hub other tdo", 32'(tdo), 0);
    step();
    shiftDr = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule